// File: doc/BRIEF.md
# Maskable Interrupt Controller with Fast-Path Steering

This block gathers interrupt requests from GPIO pins and on-chip peripherals into one 32-bit pending vector. Each source is gated by an enable bit and then sent to one of two processor request lines: a normal interrupt (`irq_o`) or a fast interrupt (`fiq_o`). A per-source route bit picks the line. The low GPIO pins each get their own source slot. The upper group of GPIO pins is folded into a single summary slot, so software finds the pin by asking the GPIO block.

A second path serves low-power operation. `idle_wake_o` ends a wait-for-interrupt idle. A control bit decides whether that idle sees every pending source or only the enabled ones. While the system sleeps, `wake_req_o` asks the power sequencer to wake up. Only GPIO events and the real-time-clock alarm can raise it, and each of them has its own wake-enable bit.

Software reaches the registers through a plain single-cycle register port: a write strobe, an address and write data, with combinational read data. This is control traffic, so the port has no valid/ready handshake and never applies back-pressure. Sources hold their requests at a level until they are serviced, and a source is cleared at the source itself.

Top module: `intc_steer`

## Requirements
- R1: A source whose enable bit (address 1, bit n for source n) is 0 has no effect on `irq_o` or `fiq_o`.
- R2: An enabled pending source drives `irq_o` when its route bit (address 2, bit n) is 0 and drives `fiq_o` when it is 1. Each output is the OR over its own sources.
- R3: After reset the enable, route, idle-gate and wake-enable registers read 0. With every source active, `irq_o`, `fiq_o` and `wake_req_o` are then 0.
- R4: Reading address 0 returns the pending vector, laid out as follows. Bits 0..10 are GPIO events 0..10. Bit 11 is the OR of GPIO events 11..27. Bits 12..31 are peripheral requests 0..19. The value follows the inputs in the same cycle and is never latched.
- R5: Writes take effect at the next clock edge. The register map is: address 1 enable, address 2 route, address 3 bit 0 idle gate, address 4 wake enable (bits 0..27 for GPIO pins 0..27, bit 31 for the RTC alarm). A write to address 0 changes nothing.
- R6: While the idle gate is 1, `idle_wake_o` is 1 exactly when some enabled source is pending.
- R7: While the idle gate is 0, `idle_wake_o` is 1 whenever any source is pending, whether enabled or not.
- R8: While `sleep_i` is 1, `wake_req_o` goes to 1 one clock after an enabled GPIO event or an enabled RTC alarm becomes active. Events that are not enabled do not raise it.
- R9: `wake_req_o` is 0 one clock after a cycle in which `sleep_i` is 0.
- R10: `irq_o`, `fiq_o` and `idle_wake_o` respond in the same cycle as their inputs, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_evt_i | input | 28 | GPIO event requests, level-held |
| periph_req_i | input | 20 | Peripheral requests for sources 12..31 |
| rtc_alarm_i | input | 1 | Real-time-clock alarm |
| sleep_i | input | 1 | System is asleep |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| idle_wake_o | output | 1 | Ends wait-for-interrupt idle |
| wake_req_o | output | 1 | Registered wake request to power sequencer |

## Verification
The bench builds the block with its default parameters: 32 sources, 11 direct GPIO slots and 28 GPIO pins. With these values the summary slot sits at bit 11, the top peripheral lands on source 31, and the highest GPIO pin (27) can be checked both through the summary bit and against the RTC wake bit at position 31. The vector table combines enable and route patterns so that both outputs, the summary fold and the outermost sources are each seen on and off.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WAKE  = 3'd4;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_GPIO = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  route_o,
  output logic              gate_o,
  output logic [N_GPIO-1:0] wk_gpio_o,
  output logic              wk_rtc_o,
  output logic [N_SRC-1:0]  rdata_o
);
  localparam int RTC_BIT = N_SRC - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o    <= '0;
      route_o   <= '0;
      gate_o    <= 1'b0;
      wk_gpio_o <= '0;
      wk_rtc_o  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_MASK:  mask_o  <= wdata_i;
        A_ROUTE: route_o <= wdata_i;
        A_CTRL:  gate_o  <= wdata_i[0];
        A_WAKE: begin
          wk_gpio_o <= wdata_i[N_GPIO-1:0];
          wk_rtc_o  <= wdata_i[RTC_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PEND:  rdata_o = pend_i;
      A_MASK:  rdata_o = mask_o;
      A_ROUTE: rdata_o = route_o;
      A_CTRL:  rdata_o[0] = gate_o;
      A_WAKE: begin
        rdata_o[N_GPIO-1:0] = wk_gpio_o;
        rdata_o[RTC_BIT]    = wk_rtc_o;
      end
      default: rdata_o = '0;
    endcase
  end

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_MASK) |=> (mask_o == $past(wdata_i)));
  assert_route_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_ROUTE) |=> (route_o == $past(wdata_i)));
  assert_pend_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_PEND) |=> ($stable(mask_o) && $stable(route_o) && $stable(gate_o)));
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] route_i,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [N_SRC-1:0] irq_hit;
  logic [N_SRC-1:0] fiq_hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic live;
    assign live       = pend_i[i] & mask_i[i];
    assign irq_hit[i] = live & ~route_i[i];
    assign fiq_hit[i] = live &  route_i[i];
  end

  assign irq_o = |irq_hit;
  assign fiq_o = |fiq_hit;

  assert_masked_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_i & mask_i)) |-> (!irq_o && !fiq_o));
  assert_fiq_has_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (|route_i));
  assert_irq_has_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !(&route_i));
endmodule

// File: rtl/intc_wake.sv
module intc_wake #(
  parameter int N_GPIO = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic [N_GPIO-1:0] gpio_evt_i,
  input  logic              rtc_i,
  input  logic [N_GPIO-1:0] en_gpio_i,
  input  logic              en_rtc_i,
  output logic              wake_req_o
);
  logic cause;
  assign cause = (|(gpio_evt_i & en_gpio_i)) | (rtc_i & en_rtc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req_o <= 1'b0;
    else        wake_req_o <= sleep_i & cause;
  end

  assert_wake_only_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> $past(sleep_i));
  assert_wake_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> ($past(|(gpio_evt_i & en_gpio_i)) || $past(rtc_i && en_rtc_i)));
endmodule

// File: rtl/intc_steer.sv
module intc_steer
  import intc_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int N_DIRECT = 11,
  parameter int N_GPIO   = 28
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_GPIO-1:0]            gpio_evt_i,
  input  logic [N_SRC-N_DIRECT-2:0]    periph_req_i,
  input  logic                         rtc_alarm_i,
  input  logic                         sleep_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [N_SRC-1:0]             reg_wdata_i,
  output logic [N_SRC-1:0]             reg_rdata_o,
  output logic                         irq_o,
  output logic                         fiq_o,
  output logic                         idle_wake_o,
  output logic                         wake_req_o
);
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  mask_q;
  logic [N_SRC-1:0]  route_q;
  logic              gate_q;
  logic [N_GPIO-1:0] wk_gpio_q;
  logic              wk_rtc_q;
  logic              grp_sum;

  assign grp_sum = |gpio_evt_i[N_GPIO-1:N_DIRECT];
  assign pend    = {periph_req_i, grp_sum, gpio_evt_i[N_DIRECT-1:0]};

  intc_regs #(.N_SRC(N_SRC), .N_GPIO(N_GPIO)) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend), .mask_o(mask_q), .route_o(route_q),
    .gate_o(gate_q), .wk_gpio_o(wk_gpio_q), .wk_rtc_o(wk_rtc_q), .rdata_o(reg_rdata_o)
  );

  intc_route #(.N_SRC(N_SRC)) route_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask_q), .route_i(route_q),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  intc_wake #(.N_GPIO(N_GPIO)) wake_i (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .gpio_evt_i(gpio_evt_i),
    .rtc_i(rtc_alarm_i), .en_gpio_i(wk_gpio_q), .en_rtc_i(wk_rtc_q),
    .wake_req_o(wake_req_o)
  );

  assign idle_wake_o = gate_q ? |(pend & mask_q) : |pend;

  assert_idle_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !(irq_o || fiq_o)) |-> !idle_wake_o);
  assert_idle_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && (|gpio_evt_i || |periph_req_i)) |-> idle_wake_o);
  assert_idle_follows_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> idle_wake_o);
endmodule

// File: tb/intc_steer_tb.sv
`timescale 1ns/1ps
module intc_steer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] gpio;
  logic [19:0] per;
  logic        rtc, slp, we;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, fiq, idle, wake;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  intc_steer dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_evt_i(gpio), .periph_req_i(per),
    .rtc_alarm_i(rtc), .sleep_i(slp), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
    .idle_wake_o(idle), .wake_req_o(wake)
  );

  typedef struct packed {
    logic [27:0] g;
    logic [19:0] p;
    logic [31:0] m;
    logic [31:0] l;
    logic        ei;
    logic        ef;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{28'h0000008, 20'h0, 32'h0000_0008, 32'h0000_0000, 1'b1, 1'b0},
    '{28'h0000008, 20'h0, 32'h0000_0008, 32'h0000_0008, 1'b0, 1'b1},
    '{28'h0000008, 20'h0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    '{28'h0100000, 20'h0, 32'h0000_0800, 32'h0000_0000, 1'b1, 1'b0},
    '{28'h8000000, 20'h0, 32'h0000_0800, 32'h0000_0800, 1'b0, 1'b1},
    '{28'h0000000, 20'h80000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0},
    '{28'h0000001, 20'h00001, 32'h0000_1001, 32'h0000_1000, 1'b1, 1'b1},
    '{28'h0000000, 20'hFFFFF, 32'hFFFF_F000, 32'hFFFF_F000, 1'b0, 1'b1},
    '{28'h0000400, 20'h0, 32'h0000_0800, 32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] pend_of(input logic [27:0] g, input logic [19:0] p);
    return {p, |g[27:11], g[10:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; gpio = '0; per = '0; rtc = 1'b0; slp = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state with every source and wake cause active
    gpio = '1; per = '1; rtc = 1'b1; slp = 1'b1;
    rd(3'd1, r); chk("R3 mask", r, 32'h0);
    rd(3'd2, r); chk("R3 route", r, 32'h0);
    rd(3'd3, r); chk("R3 gate", r, 32'h0);
    rd(3'd4, r); chk("R3 wake-en", r, 32'h0);
    chk("R3 irq/fiq", {30'h0, irq, fiq}, 32'h0);
    @(negedge clk); chk("R3 wake_req", {31'h0, wake}, 32'h0);
    // R7 gate clear after reset: any pending ends idle
    chk("R7 idle open", {31'h0, idle}, 32'h1);
    gpio = '0; per = '0; rtc = 1'b0; slp = 1'b0;

    // Vector table: R1 R2 R4 R10
    foreach (VEC[i]) begin
      wr(3'd1, VEC[i].m);
      wr(3'd2, VEC[i].l);
      @(negedge clk);
      gpio = VEC[i].g; per = VEC[i].p;
      #1;
      chk($sformatf("R1/R2/R10 vec%0d irq", i), {31'h0, irq}, {31'h0, VEC[i].ei});
      chk($sformatf("R1/R2/R10 vec%0d fiq", i), {31'h0, fiq}, {31'h0, VEC[i].ef});
      rd(3'd0, r);
      chk($sformatf("R4 vec%0d pend", i), r, pend_of(VEC[i].g, VEC[i].p));
    end

    // R4 pending drops as soon as the source drops
    gpio = '0; per = '0;
    rd(3'd0, r); chk("R4 no latch", r, 32'h0);

    // R5 write to pending address ignored
    wr(3'd1, 32'h0000_00F0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, r); chk("R5 pend ro", r, 32'h0);
    rd(3'd1, r); chk("R5 mask kept", r, 32'h0000_00F0);

    // R6 gate set: only enabled sources end idle
    wr(3'd3, 32'h1);
    wr(3'd1, 32'h0);
    @(negedge clk); gpio = 28'h20; #1;
    chk("R6 masked no idle", {31'h0, idle}, 32'h0);
    wr(3'd1, 32'h20); #1;
    chk("R6 enabled idle", {31'h0, idle}, 32'h1);
    // R7 gate clear: masked source ends idle
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0); #1;
    chk("R7 masked idle", {31'h0, idle}, 32'h1);
    gpio = '0;

    // R8 wake request, one cycle latency
    wr(3'd4, 32'h8000_0010);
    rd(3'd4, r); chk("R5 wake-en map", r, 32'h8000_0010);
    slp = 1'b1;
    @(negedge clk); gpio = 28'h10; #1;
    chk("R8 not yet", {31'h0, wake}, 32'h0);
    @(negedge clk); chk("R8 gpio wake", {31'h0, wake}, 32'h1);
    gpio = 28'h20;
    @(negedge clk); chk("R8 disabled pin", {31'h0, wake}, 32'h0);
    gpio = '0; rtc = 1'b1;
    @(negedge clk); chk("R8 rtc wake", {31'h0, wake}, 32'h1);
    // R9 not asleep
    slp = 1'b0;
    @(negedge clk); chk("R9 awake", {31'h0, wake}, 32'h0);
    rtc = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule